// File: doc/BRIEF.md
# Real-Time Clock Alarm Comparator with Wildcard Fields

This block decides, once per clock-time update, whether the programmed alarm matches the current time of day. It takes three alarm bytes (seconds, minutes, hours) and the matching three time-of-day bytes. On each update-ended strobe it produces a one-cycle alarm event, which the neighbouring flag logic latches.

Any alarm byte can be made a wildcard, so the alarm can fire every second, every minute, every hour or once a day. All bytes are decoded under the current data encoding, either packed BCD or plain binary. In 12-hour format, the hour bytes are converted to a 0..23 value before the comparison.

A level input, `freeze`, is high while the time registers are being loaded or the divider chain is held in reset. While it is high, no comparison takes place.

The sequencing is a three-state machine:
- `ST_RUN`: idle and armed.
- `ST_FIRE`: the single cycle in which the event is driven.
- `ST_HOLD`: comparisons are suppressed.

Its transitions are:
- RUN to FIRE on a strobe that matches.
- Any state to HOLD while `freeze` is high.
- HOLD to RUN, or HOLD to FIRE on a matching strobe, once `freeze` drops.
- FIRE back to RUN (or to HOLD) after one cycle.

Top module: `rtcal_alarm_match`

## Requirements
- R1: After reset `alarm_hit` is low, and it stays low until a strobe with matching fields has been sampled.
- R2: An alarm byte whose bits [7:6] are both 1 is a wildcard and matches any current value, whatever its low six bits hold.
- R3: With all three alarm bytes wildcarded, every strobe sampled with `freeze` low produces an event.
- R4: With only the seconds byte specified, an event occurs exactly when the decoded seconds are equal; minutes and hours have no effect.
- R5: With seconds and minutes specified and hours wildcarded, both must be equal; the hour has no effect.
- R6: With all three bytes specified, all three decoded values must be equal.
- R7: When `bin_mode` is 0, bytes are decoded as packed BCD, value = 10 × bits[7:4] + bits[3:0]. For example, 0x0A and 0x10 both decode to 10. When `bin_mode` is 1, the byte value is used directly.
- R8: When `hr24_mode` is 0, each hour byte uses bit 7 as PM. The low seven bits are decoded, reduced modulo 12 (so 12 becomes 0) and raised by 12 when PM is set. When `hr24_mode` is 1, the whole hour byte is decoded with no PM handling.
- R9: A strobe sampled while `freeze` is high produces no event.
- R10: An event is `alarm_hit` high for exactly one cycle: the cycle after the clock edge that sampled the strobe.
- R11: A change to an alarm byte takes effect at the very next strobe; no earlier alarm value is retained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_strobe | input | 1 | One-cycle pulse at the end of each time update |
| freeze | input | 1 | High while time is being set or the divider is in reset |
| bin_mode | input | 1 | 1 = binary encoding, 0 = BCD |
| hr24_mode | input | 1 | 1 = 24-hour format, 0 = 12-hour with PM in bit 7 |
| alm_sec | input | 8 | Alarm seconds byte |
| alm_min | input | 8 | Alarm minutes byte |
| alm_hr | input | 8 | Alarm hours byte |
| cur_sec | input | 8 | Current seconds byte |
| cur_min | input | 8 | Current minutes byte |
| cur_hr | input | 8 | Current hours byte |
| alarm_hit | output | 1 | One-cycle alarm event |

## Verification
The comparison is exercised with the following alarm patterns:
- All fields wildcarded.
- Seconds specified alone.
- Seconds and minutes specified.
- All three fields specified.

Each pattern is paired with a matching time and with a time that differs in exactly one specified field. This shows which fields actually participate in the comparison.

Encoding is tested with one byte pair that is equal only under BCD decoding, and with binary bytes above 0x39. The hour tests cover:
- 12 AM against 0.
- A PM byte against its plain-hour twin.
- The same byte pair under 24-hour format.

Together these separate PM handling from the modulo-12 wrap. Directed sequences check suppression while `freeze` is high, the width of the event, and an alarm change between two strobes.

// File: rtl/rtcal_pkg.sv
package rtcal_pkg;
    localparam int BYTE_W  = 8;
    localparam int VAL_W   = 8;
    localparam int NFIELDS = 3;
    localparam int HOUR_IX = 2;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HOLD = 2'd1,
        ST_FIRE = 2'd2
    } cmp_state_t;

    function automatic logic [VAL_W-1:0] bcd_value(input logic [BYTE_W-1:0] b);
        logic [VAL_W-1:0] tens;
        logic [VAL_W-1:0] ones;
        tens = VAL_W'(b[7:4]);
        ones = VAL_W'(b[3:0]);
        return VAL_W'(tens * VAL_W'(10)) + ones;
    endfunction
endpackage

// File: rtl/rtcal_field_decode.sv
module rtcal_field_decode
    import rtcal_pkg::*;
#(
    parameter bit IS_HOUR = 1'b0
) (
    input  logic [BYTE_W-1:0] raw,
    input  logic              bin_mode,
    input  logic              hr24_mode,
    output logic              wild,
    output logic [VAL_W-1:0]  value
);
    logic              twelve;
    logic [BYTE_W-1:0] low7;
    logic [VAL_W-1:0]  base;

    assign wild   = (raw[7:6] == 2'b11);
    assign twelve = IS_HOUR && !hr24_mode;
    assign low7   = {1'b0, raw[6:0]};

    always_comb begin
        if (twelve) begin
            base  = bin_mode ? VAL_W'(low7) : bcd_value(low7);
            value = (base % VAL_W'(12)) + (raw[7] ? VAL_W'(12) : VAL_W'(0));
        end else begin
            base  = bin_mode ? VAL_W'(raw) : bcd_value(raw);
            value = base;
        end
    end
endmodule

// File: rtl/rtcal_match_fsm.sv
module rtcal_match_fsm
    import rtcal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic upd_strobe,
    input  logic freeze,
    input  logic hit_now,
    output logic alarm_hit
);
    cmp_state_t state_q;
    cmp_state_t state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN, ST_HOLD: begin
                if (freeze)                      state_d = ST_HOLD;
                else if (upd_strobe && hit_now)  state_d = ST_FIRE;
                else                             state_d = ST_RUN;
            end
            ST_FIRE: begin
                if (freeze) state_d = ST_HOLD;
                else        state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        alarm_hit = (state_q == ST_FIRE);
    end

    // R10
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |=> !alarm_hit);

    // R10
    pulse_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |-> $past(upd_strobe && hit_now));

    // R9
    freeze_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> !alarm_hit);

    // R6
    match_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_strobe && hit_now && !freeze && !alarm_hit) |=> alarm_hit);
endmodule

// File: rtl/rtcal_alarm_match.sv
module rtcal_alarm_match
    import rtcal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_strobe,
    input  logic              freeze,
    input  logic              bin_mode,
    input  logic              hr24_mode,
    input  logic [BYTE_W-1:0] alm_sec,
    input  logic [BYTE_W-1:0] alm_min,
    input  logic [BYTE_W-1:0] alm_hr,
    input  logic [BYTE_W-1:0] cur_sec,
    input  logic [BYTE_W-1:0] cur_min,
    input  logic [BYTE_W-1:0] cur_hr,
    output logic              alarm_hit
);
    logic [BYTE_W-1:0] alm_raw [NFIELDS];
    logic [BYTE_W-1:0] cur_raw [NFIELDS];
    logic [VAL_W-1:0]  alm_val [NFIELDS];
    logic [VAL_W-1:0]  cur_val [NFIELDS];
    logic [NFIELDS-1:0] alm_wild;
    logic [NFIELDS-1:0] cur_wild;
    logic [NFIELDS-1:0] field_ok;
    logic               hit_now;

    assign alm_raw[0] = alm_sec;
    assign alm_raw[1] = alm_min;
    assign alm_raw[2] = alm_hr;
    assign cur_raw[0] = cur_sec;
    assign cur_raw[1] = cur_min;
    assign cur_raw[2] = cur_hr;

    for (genvar i = 0; i < NFIELDS; i++) begin : g_field
        rtcal_field_decode #(.IS_HOUR(i == HOUR_IX)) u_alm (
            .raw       (alm_raw[i]),
            .bin_mode  (bin_mode),
            .hr24_mode (hr24_mode),
            .wild      (alm_wild[i]),
            .value     (alm_val[i])
        );
        rtcal_field_decode #(.IS_HOUR(i == HOUR_IX)) u_cur (
            .raw       (cur_raw[i]),
            .bin_mode  (bin_mode),
            .hr24_mode (hr24_mode),
            .wild      (cur_wild[i]),
            .value     (cur_val[i])
        );
        assign field_ok[i] = alm_wild[i] || (alm_val[i] == cur_val[i]);
    end

    assign hit_now = &field_ok;

    rtcal_match_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_strobe (upd_strobe),
        .freeze     (freeze),
        .hit_now    (hit_now),
        .alarm_hit  (alarm_hit)
    );

    // R3
    all_wild_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_strobe && !freeze && !alarm_hit && (&alm_wild)) |=> alarm_hit);

    // R2
    wild_field_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_sec[7:6] == 2'b11) |-> field_ok[0]);

    logic unused_cur_wild;
    assign unused_cur_wild = ^cur_wild;
endmodule

// File: tb/test_rtcal_alarm_match.sv
module test_rtcal_alarm_match;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic upd_strobe = 1'b0;
    logic freeze = 1'b0;
    logic bin_mode = 1'b0;
    logic hr24_mode = 1'b1;
    logic [7:0] alm_sec = 8'hC0, alm_min = 8'hC0, alm_hr = 8'hC0;
    logic [7:0] cur_sec = 8'h00, cur_min = 8'h00, cur_hr = 8'h00;
    logic alarm_hit;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    rtcal_alarm_match i_rtcal_alarm_match (
        .clk(clk), .rst_n(rst_n), .upd_strobe(upd_strobe), .freeze(freeze),
        .bin_mode(bin_mode), .hr24_mode(hr24_mode),
        .alm_sec(alm_sec), .alm_min(alm_min), .alm_hr(alm_hr),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hr(cur_hr),
        .alarm_hit(alarm_hit)
    );

    // fields: req[54:51] bin hr24 as am ah ts tm th exp
    localparam int NV = 17;
    localparam logic [54:0] VEC [NV] = '{
        {4'd3, 1'b0, 1'b1, 8'hC0, 8'hC0, 8'hC0, 8'h12, 8'h34, 8'h05, 1'b1}, // R3
        {4'd2, 1'b0, 1'b1, 8'hFF, 8'hC5, 8'hD2, 8'h59, 8'h00, 8'h23, 1'b1}, // R2
        {4'd4, 1'b0, 1'b1, 8'h30, 8'hC0, 8'hC0, 8'h30, 8'h17, 8'h09, 1'b1}, // R4
        {4'd4, 1'b0, 1'b1, 8'h30, 8'hC0, 8'hC0, 8'h31, 8'h17, 8'h09, 1'b0}, // R4
        {4'd5, 1'b0, 1'b1, 8'h15, 8'h45, 8'hC0, 8'h15, 8'h45, 8'h22, 1'b1}, // R5
        {4'd5, 1'b0, 1'b1, 8'h15, 8'h45, 8'hC0, 8'h15, 8'h44, 8'h22, 1'b0}, // R5
        {4'd6, 1'b0, 1'b1, 8'h00, 8'h30, 8'h07, 8'h00, 8'h30, 8'h07, 1'b1}, // R6
        {4'd6, 1'b0, 1'b1, 8'h00, 8'h30, 8'h07, 8'h00, 8'h30, 8'h08, 1'b0}, // R6
        {4'd7, 1'b0, 1'b1, 8'h0A, 8'hC0, 8'hC0, 8'h10, 8'h00, 8'h00, 1'b1}, // R7
        {4'd7, 1'b1, 1'b1, 8'h0A, 8'hC0, 8'hC0, 8'h10, 8'h00, 8'h00, 1'b0}, // R7
        {4'd7, 1'b1, 1'b1, 8'h3B, 8'h3B, 8'h17, 8'h3B, 8'h3B, 8'h17, 1'b1}, // R7
        {4'd8, 1'b0, 1'b0, 8'hC0, 8'hC0, 8'h12, 8'h00, 8'h00, 8'h00, 1'b1}, // R8
        {4'd8, 1'b0, 1'b0, 8'hC0, 8'hC0, 8'h01, 8'h00, 8'h00, 8'h81, 1'b0}, // R8
        {4'd8, 1'b0, 1'b0, 8'hC0, 8'hC0, 8'h80, 8'h00, 8'h00, 8'h92, 1'b1}, // R8
        {4'd8, 1'b0, 1'b1, 8'hC0, 8'hC0, 8'h12, 8'h00, 8'h00, 8'h92, 1'b0}, // R8
        {4'd8, 1'b1, 1'b0, 8'hC0, 8'hC0, 8'h8C, 8'h00, 8'h00, 8'h80, 1'b1}, // R8
        {4'd6, 1'b0, 1'b0, 8'h05, 8'h10, 8'h93, 8'h05, 8'h10, 8'h93, 1'b1}  // R6
    };

    task automatic check(input bit ok, input int req, input logic act, input logic exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL R%0d: alarm_hit=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // strobe for one cycle, check the event cycle and the cycle after (R10)
    task automatic pulse_and_check(input logic exp, input int req);
        @(negedge clk) upd_strobe = 1'b1;
        @(negedge clk) upd_strobe = 1'b0;
        check(alarm_hit == exp, req, alarm_hit, exp);
        @(negedge clk);
        check(alarm_hit == 1'b0, 10, alarm_hit, 1'b0); // R10 width
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: quiet after reset, even with matching inputs and no strobe
        repeat (2) @(negedge clk);
        check(alarm_hit == 1'b0, 1, alarm_hit, 1'b0);

        for (int i = 0; i < NV; i++) begin
            logic [54:0] v;
            v = VEC[i];
            @(negedge clk);
            bin_mode  = v[50];
            hr24_mode = v[49];
            alm_sec   = v[48:41];
            alm_min   = v[40:33];
            alm_hr    = v[32:25];
            cur_sec   = v[24:17];
            cur_min   = v[16:9];
            cur_hr    = v[8:1];
            pulse_and_check(v[0], int'(v[54:51]));
        end

        // R9: strobe while frozen gives nothing, then works once released
        @(negedge clk);
        bin_mode = 1'b0; hr24_mode = 1'b1;
        alm_sec = 8'hC0; alm_min = 8'hC0; alm_hr = 8'hC0;
        freeze = 1'b1;
        pulse_and_check(1'b0, 9);
        @(negedge clk) freeze = 1'b0;
        pulse_and_check(1'b1, 9);

        // R11: alarm change between strobes is used at the next strobe
        @(negedge clk);
        alm_sec = 8'h20; cur_sec = 8'h20;
        pulse_and_check(1'b1, 11);
        @(negedge clk) alm_sec = 8'h21;
        pulse_and_check(1'b0, 11);
        @(negedge clk) cur_sec = 8'h21;
        pulse_and_check(1'b1, 11);

        // R1: reset mid-run returns output low
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        check(alarm_hit == 1'b0, 1, alarm_hit, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check(alarm_hit == 1'b0, 1, alarm_hit, 1'b0);

        finish_run();
    end
endmodule